// File: doc/BRIEF.md
# Interrupt Redirection Table Unit

This block collects a bank of interrupt pins and turns each asserted pin into one delivery message. A table with one two-word entry per pin sets how each pin's message looks. The low word of an entry holds the pin's active level, the vector, the delivery mode and the addressing style. It also shows a read-only flag that stays set while the message waits for the downstream receiver. The high word holds two 8-bit destination fields, and the block packs them into a message address.

Software reaches the table through a pair of registers. The first is an 8-bit index register. The second is a data window that reads or writes the word the index selects. Each pin is synchronised through two flops and adjusted for its active level. A change into the active state marks a request as pending. A fixed priority, lowest pin first, chooses which pending request is offered on a valid/ready port. A request is dropped from pending only when the handshake completes.

Top module: `irq_route_unit`

## Requirements
- R1: After a synchronous active-low reset, the index register reads 00h, every table word reads zero and `msg_valid` is low.
- R2: Writing the index port (`cfg_sel`=0) stores `cfg_wdata[7:0]` and reads it back there. Through the window (`cfg_sel`=1), index 10h+2n selects the low word of pin n and index 11h+2n selects its high word, for n = 0..23.
- R3: At any index outside 10h..3Fh the window reads zero, and writes there change no table word.
- R4: The low word uses bit 13 for active level (0 = high, 1 = low), bit 11 for addressing style (0 = physical, 1 = logical), bits [10:8] for delivery mode and bits [7:0] for the vector. Bit 12 is the read-only pending flag, and writes to it are ignored. All other bits read zero.
- R5: The high word stores bits [31:24] as the primary destination and bits [23:16] as the extended destination. Bits [15:0] read zero.
- R6: With active level high, a rising pin edge raises a request. With active level low, a falling edge raises one. An edge in the inactive direction raises none, and a change of the level setting alone raises none.
- R7: Requests are edge-triggered. A pin held in its active state after its request is accepted raises no further request.
- R8: An entry raises no request if its delivery mode is anything other than 000 or 001, or if its vector is below 10h or equal to FFh. Vectors 10h and FEh are accepted.
- R9: While `msg_valid` is high, the outputs show the chosen entry's vector, mode and addressing style. `msg_addr[19:12]` is the primary destination in logical style, or `{4'h0, dest[3:0]}` in physical style. `msg_addr[11:4]` is the extended destination, and `msg_addr[3:0]` is zero.
- R10: The pending flag of a pin reads 1 from the cycle after its edge is detected until the handshake (`msg_valid` and `msg_ready` both high) completes, and reads 0 after that.
- R11: Among pending pins, the lowest-numbered one is offered. Once offered and not accepted, it stays offered even if a lower pin becomes pending later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_sel | input | 1 | 0 selects the index register, 1 selects the data window |
| cfg_we | input | 1 | Write strobe for the selected register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| irq_pin | input | 24 | Asynchronous interrupt pins |
| msg_valid | output | 1 | A delivery message is offered |
| msg_ready | input | 1 | Receiver accepts the offered message |
| msg_vector | output | 8 | Vector of the offered message |
| msg_dlv_mode | output | 3 | Delivery mode of the offered message |
| msg_logical | output | 1 | Addressing style: 1 logical, 0 physical |
| msg_addr | output | 20 | Message address built from the destination fields |

## Verification
The hardest state to reach from the ports is a waiting request that has to keep its grant while a lower-numbered pin becomes pending behind it. The bench reaches it by holding `msg_ready` low, raising a higher pin first and then a lower one. It confirms that the offered vector does not change and that the lower pin goes out only after the handshake. It also raises two pins in the same cycle, to check the order when requests arrive together and the pending flags of both pins during the wait.

// File: rtl/irq_route_pkg.sv
// Shared types and helpers for the interrupt redirection table unit.
// Assumes an 8-bit vector, a 3-bit delivery mode and 8-bit destination fields.
package irq_route_pkg;

    localparam logic [2:0] DM_FIXED  = 3'b000;
    localparam logic [2:0] DM_LOWPRI = 3'b001;
    localparam logic [7:0] VEC_MIN   = 8'h10;
    localparam logic [7:0] VEC_MAX   = 8'hFE;

    // Low-word bit positions decoded by software.
    localparam int LO_POL_BIT  = 13;
    localparam int LO_PEND_BIT = 12;
    localparam int LO_LOG_BIT  = 11;

    typedef struct packed {
        logic       act_low;
        logic       logical;
        logic [2:0] mode;
        logic [7:0] vec;
        logic [7:0] dest;
        logic [7:0] ext;
    } irt_entry_t;

    // True when the entry may produce a delivery request.
    function automatic logic entry_deliverable(irt_entry_t e);
        return ((e.mode == DM_FIXED) || (e.mode == DM_LOWPRI)) &&
               (e.vec >= VEC_MIN) && (e.vec <= VEC_MAX);
    endfunction

    // Packs destination fields into the 20-bit message address.
    function automatic logic [19:0] msg_address(irt_entry_t e);
        logic [7:0] d;
        d = e.logical ? e.dest : {4'h0, e.dest[3:0]};
        return {d, e.ext, 4'h0};
    endfunction

endpackage

// File: rtl/irq_pin_front.sv
// One pin's input front end: a synchroniser chain plus one history flop, and
// an edge detector that honours the pin's active level. The history flop holds
// the raw level, so a change of the level setting alone never looks like an edge.
// Assumes the pin is asynchronous to clk and stays stable for a few cycles.
module irq_pin_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic act_low,
    output logic edge_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_q;
    logic            lvl_now;
    logic            lvl_old;

    // Shift the raw pin level through the synchroniser and history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SH_W-2:0], pin};
    end

    assign lvl_now = sh_q[SYNC_STAGES-1];
    assign lvl_old = sh_q[SYNC_STAGES];

    // Detect a transition into the active state.
    always_comb begin
        if (act_low) edge_o = lvl_old & ~lvl_now;
        else         edge_o = lvl_now & ~lvl_old;
    end

    // R7: under a steady active-high setting, an edge is never reported twice in a row.
    p_single_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o && !act_low) |=> !(edge_o && !act_low));

endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority selector, lowest request index wins. While an offer is not
// accepted, the granted index is held, so the payload stays put under backpressure.
// Assumes a request stays set until its handshake completes.
module irq_prio_pick #(
    parameter int N  = 24,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          accept,
    output logic          gnt_vld,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] low_idx;
    logic          held_q;
    logic [IW-1:0] held_idx_q;

    // Find the lowest set request bit.
    always_comb begin
        low_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) low_idx = IW'(i);
        end
    end

    // Remember an offer that the receiver did not take this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q     <= 1'b0;
            held_idx_q <= '0;
        end else begin
            held_q     <= gnt_vld && !accept;
            held_idx_q <= gnt_idx;
        end
    end

    assign gnt_vld = |req;
    assign gnt_idx = held_q ? held_idx_q : low_idx;

    // R11: a refused offer keeps its index in the next cycle.
    p_grant_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && !accept) |=> (gnt_idx == $past(gnt_idx)));

    // R11: the offered index always belongs to a live request.
    p_grant_live_r11: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> req[gnt_idx]);

endmodule

// File: rtl/irq_route_unit.sv
// Interrupt redirection table unit (top). Holds one two-word entry per pin,
// reached through an index register and a data window. It detects active edges
// on the pins, keeps a pending flag for each pin and offers one message at a time
// on a valid/ready port. Assumes software does not rewrite an entry while its
// pin is pending.
module irq_route_unit
    import irq_route_pkg::*;
#(
    parameter int N_PINS      = 24,
    parameter int IDX_W       = 8,
    parameter int WIN_BASE_I  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [N_PINS-1:0] irq_pin,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [7:0]        msg_vector,
    output logic [2:0]        msg_dlv_mode,
    output logic              msg_logical,
    output logic [19:0]       msg_addr
);
    localparam int             ENT_W    = $clog2(N_PINS);
    localparam logic [IDX_W-1:0] WIN_BASE = IDX_W'(WIN_BASE_I);
    localparam logic [IDX_W-1:0] WIN_LAST = IDX_W'(WIN_BASE_I + 2 * N_PINS - 1);

    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  offs;
    logic              in_win;
    logic [ENT_W-1:0]  ent_sel;
    logic              hi_sel;
    logic              win_we;
    irt_entry_t        tbl [N_PINS];
    logic [N_PINS-1:0] pend_q;
    logic [N_PINS-1:0] edge_v;
    logic [N_PINS-1:0] set_v;
    logic              gnt_vld;
    logic [ENT_W-1:0]  gnt_idx;
    logic              hs;
    irt_entry_t        cur;
    logic              unused_bits;

    assign unused_bits = ^{cfg_wdata[15:14], cfg_wdata[12], offs[IDX_W-1:ENT_W+1]};

    // Decode the index register into an entry number and a word select.
    always_comb begin
        offs    = idx_q - WIN_BASE;
        in_win  = (idx_q >= WIN_BASE) && (idx_q <= WIN_LAST);
        ent_sel = offs[ENT_W:1];
        hi_sel  = offs[0];
        win_we  = cfg_we && cfg_sel && in_win;
    end

    // Index register update.
    always_ff @(posedge clk) begin
        if (!rst_n)                 idx_q <= '0;
        else if (cfg_we && !cfg_sel) idx_q <= cfg_wdata[IDX_W-1:0];
    end

    assign hs = msg_valid && msg_ready;

    generate
        for (genvar g = 0; g < N_PINS; g++) begin : g_pin
            logic ent_we;
            logic clr;

            assign ent_we = win_we && (ent_sel == ENT_W'(g));
            assign clr    = hs && (gnt_idx == ENT_W'(g));
            assign set_v[g] = edge_v[g] && entry_deliverable(tbl[g]);

            // Table entry storage, written one word at a time.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tbl[g] <= '0;
                end else if (ent_we) begin
                    if (hi_sel) begin
                        tbl[g].dest <= cfg_wdata[31:24];
                        tbl[g].ext  <= cfg_wdata[23:16];
                    end else begin
                        tbl[g].act_low <= cfg_wdata[LO_POL_BIT];
                        tbl[g].logical <= cfg_wdata[LO_LOG_BIT];
                        tbl[g].mode    <= cfg_wdata[10:8];
                        tbl[g].vec     <= cfg_wdata[7:0];
                    end
                end
            end

            // Pending flag: set on an eligible edge, cleared by the handshake.
            always_ff @(posedge clk) begin
                if (!rst_n)      pend_q[g] <= 1'b0;
                else if (set_v[g]) pend_q[g] <= 1'b1;
                else if (clr)    pend_q[g] <= 1'b0;
            end

            irq_pin_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin     (irq_pin[g]),
                .act_low (tbl[g].act_low),
                .edge_o  (edge_v[g])
            );

            // R10: an eligible edge shows as pending in the next cycle.
            p_pend_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
                set_v[g] |=> pend_q[g]);
        end
    endgenerate

    irq_prio_pick #(.N(N_PINS), .IW(ENT_W)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (pend_q),
        .accept  (msg_ready),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    // Drive the message port from the granted entry.
    always_comb begin
        cur          = tbl[gnt_idx];
        msg_valid    = gnt_vld;
        msg_vector   = cur.vec;
        msg_dlv_mode = cur.mode;
        msg_logical  = cur.logical;
        msg_addr     = msg_address(cur);
    end

    // Read mux for the index register and the data window.
    always_comb begin
        irt_entry_t rd;
        rd        = tbl[ent_sel];
        cfg_rdata = '0;
        if (!cfg_sel) begin
            cfg_rdata[IDX_W-1:0] = idx_q;
        end else if (in_win) begin
            if (hi_sel) begin
                cfg_rdata[31:24] = rd.dest;
                cfg_rdata[23:16] = rd.ext;
            end else begin
                cfg_rdata[LO_POL_BIT]  = rd.act_low;
                cfg_rdata[LO_PEND_BIT] = pend_q[ent_sel];
                cfg_rdata[LO_LOG_BIT]  = rd.logical;
                cfg_rdata[10:8]        = rd.mode;
                cfg_rdata[7:0]         = rd.vec;
            end
        end
    end

    // R1: reset leaves no message on offer.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !msg_valid);

    // R10: an accepted request without a fresh edge is no longer pending.
    p_clear_on_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !set_v[gnt_idx]) |=> !pend_q[$past(gnt_idx)]);

endmodule

// File: tb/tb_irq_route_unit.sv
module tb_irq_route_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_sel;
    logic        cfg_we;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [23:0] irq_pin;
    logic        msg_valid;
    logic        msg_ready;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_dlv_mode;
    logic        msg_logical;
    logic [19:0] msg_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    irq_route_unit dut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_pin(irq_pin),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_dlv_mode(msg_dlv_mode), .msg_logical(msg_logical), .msg_addr(msg_addr)
    );

    // Row: {pin[39:32], act_low[31], logical[30], mode[29:27], pad[26:25],
    //       expect[24], vec[23:16], dest[15:8], ext[7:0]}
    localparam int NROWS = 13;
    localparam logic [39:0] ROWS [NROWS] = '{
        {8'd0,  1'b0, 1'b0, 3'd0, 2'b0, 1'b1, 8'h20, 8'hA5, 8'h3C},
        {8'd1,  1'b1, 1'b1, 3'd1, 2'b0, 1'b1, 8'h31, 8'hA5, 8'h11},
        {8'd2,  1'b0, 1'b0, 3'd2, 2'b0, 1'b0, 8'h40, 8'h01, 8'h02},
        {8'd3,  1'b0, 1'b0, 3'd3, 2'b0, 1'b0, 8'h40, 8'h01, 8'h02},
        {8'd4,  1'b0, 1'b0, 3'd4, 2'b0, 1'b0, 8'h40, 8'h01, 8'h02},
        {8'd5,  1'b0, 1'b0, 3'd5, 2'b0, 1'b0, 8'h40, 8'h01, 8'h02},
        {8'd6,  1'b0, 1'b0, 3'd6, 2'b0, 1'b0, 8'h40, 8'h01, 8'h02},
        {8'd7,  1'b1, 1'b0, 3'd7, 2'b0, 1'b0, 8'h40, 8'h01, 8'h02},
        {8'd8,  1'b0, 1'b0, 3'd0, 2'b0, 1'b0, 8'h0F, 8'h01, 8'h02},
        {8'd9,  1'b0, 1'b1, 3'd0, 2'b0, 1'b1, 8'h10, 8'hFF, 8'hFF},
        {8'd10, 1'b1, 1'b0, 3'd1, 2'b0, 1'b1, 8'hFE, 8'h3C, 8'h00},
        {8'd11, 1'b0, 1'b0, 3'd1, 2'b0, 1'b0, 8'hFF, 8'h01, 8'h02},
        {8'd23, 1'b0, 1'b1, 3'd0, 2'b0, 1'b1, 8'h77, 8'h12, 8'h34}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_sel = sel; cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_win(input logic [7:0] idx, input logic [31:0] d);
        wr(1'b0, {24'h0, idx});
        wr(1'b1, d);
    endtask

    task automatic rd_win(input logic [7:0] idx, output logic [31:0] d);
        wr(1'b0, {24'h0, idx});
        cfg_sel = 1'b1;
        #1 d = cfg_rdata;
    endtask

    task automatic accept_one();
        @(negedge clk); msg_ready = 1'b1;
        @(negedge clk); msg_ready = 1'b0;
    endtask

    function automatic logic [19:0] exp_addr(input logic lg, input logic [7:0] dst, input logic [7:0] ex);
        logic [7:0] hi;
        hi = lg ? dst : {4'h0, dst[3:0]};
        return {hi, ex, 4'h0};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; cfg_sel = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        irq_pin = '0; msg_ready = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1: reset state
        check("R1 valid", {31'h0, msg_valid}, 32'h0);
        cfg_sel = 1'b0; #1 check("R1 index", cfg_rdata, 32'h0);
        rd_win(8'h10, d); check("R1 pin0 low", d, 32'h0);
        rd_win(8'h3F, d); check("R1 pin23 high", d, 32'h0);

        // R2: index register readback
        wr(1'b0, 32'hFFFF_FFA7);
        cfg_sel = 1'b0; #1 check("R2 index", cfg_rdata, 32'h0000_00A7);

        // R3: unimplemented indexes
        wr_win(8'h0F, 32'hFFFF_FFFF);
        wr_win(8'h40, 32'hFFFF_FFFF);
        wr_win(8'hFF, 32'hFFFF_FFFF);
        rd_win(8'h0F, d); check("R3 read 0F", d, 32'h0);
        rd_win(8'h40, d); check("R3 read 40", d, 32'h0);
        rd_win(8'h10, d); check("R3 pin0 low intact", d, 32'h0);
        rd_win(8'h3E, d); check("R3 pin23 low intact", d, 32'h0);
        rd_win(8'h3F, d); check("R3 pin23 high intact", d, 32'h0);

        // R4 / R5: field layout, pin 12
        wr_win(8'h28, 32'hFFFF_FFFF);
        rd_win(8'h28, d); check("R4 low layout", d, 32'h0000_2FFF);
        wr_win(8'h29, 32'hFFFF_FFFF);
        rd_win(8'h29, d); check("R5 high layout", d, 32'hFFFF_0000);
        rd_win(8'h2B, d); check("R2 pin13 high separate", d, 32'h0);
        wr_win(8'h28, 32'h0);
        wr_win(8'h29, 32'h0);

        // Table walk: R6, R7, R8, R9, R10
        for (int r = 0; r < NROWS; r++) begin
            logic [7:0] pin, vec, dst, ex;
            logic pol, lg, ex_req;
            logic [2:0] md;
            pin = ROWS[r][39:32]; pol = ROWS[r][31]; lg = ROWS[r][30];
            md = ROWS[r][29:27]; ex_req = ROWS[r][24];
            vec = ROWS[r][23:16]; dst = ROWS[r][15:8]; ex = ROWS[r][7:0];
            wr_win(8'h10 + 2 * pin, {18'h0, pol, 1'b0, lg, md, vec});
            wr_win(8'h11 + 2 * pin, {dst, ex, 16'h0});
            if (pol) begin
                @(negedge clk); irq_pin[pin] = 1'b1;
                cyc(5);
                check("R6 inactive edge", {31'h0, msg_valid}, 32'h0);
            end
            @(negedge clk); irq_pin[pin] = ~pol;
            cyc(5);
            check(ex_req ? "R9 valid" : "R8 blocked", {31'h0, msg_valid}, {31'h0, ex_req});
            rd_win(8'h10 + 2 * pin, d);
            check("R10 pending flag", {31'h0, d[12]}, {31'h0, ex_req});
            if (ex_req) begin
                check("R9 vector", {24'h0, msg_vector}, {24'h0, vec});
                check("R9 mode", {29'h0, msg_dlv_mode}, {29'h0, md});
                check("R9 logical", {31'h0, msg_logical}, {31'h0, lg});
                check("R9 addr", {12'h0, msg_addr}, {12'h0, exp_addr(lg, dst, ex)});
                accept_one();
                cyc(5);
                check("R7 held level", {31'h0, msg_valid}, 32'h0);
                rd_win(8'h10 + 2 * pin, d);
                check("R10 cleared", {31'h0, d[12]}, 32'h0);
            end
            @(negedge clk); irq_pin[pin] = pol;
            cyc(5);
            check("R6 release", {31'h0, msg_valid}, 32'h0);
        end

        // R6: level setting change alone, pin 13
        wr_win(8'h2A, 32'h0000_0050);
        cyc(4);
        wr_win(8'h2A, 32'h0000_2050);
        cyc(5);
        check("R6 level change only", {31'h0, msg_valid}, 32'h0);

        // R4: pending bit not writable, pin 17
        wr_win(8'h32, 32'h0000_1071);
        rd_win(8'h32, d); check("R4 pending write ignored", d, 32'h0000_0071);

        // R11: grant hold under backpressure, pins 14 and 15
        wr_win(8'h2C, 32'h0000_0060);
        wr_win(8'h2E, 32'h0000_0061);
        @(negedge clk); irq_pin[15] = 1'b1;
        cyc(5);
        check("R11 first offer", {24'h0, msg_vector}, 32'h61);
        @(negedge clk); irq_pin[14] = 1'b1;
        cyc(5);
        check("R11 held valid", {31'h0, msg_valid}, 32'h1);
        check("R11 held vector", {24'h0, msg_vector}, 32'h61);
        accept_one();
        check("R11 next offer", {24'h0, msg_vector}, 32'h60);
        accept_one();
        check("R11 drained", {31'h0, msg_valid}, 32'h0);

        // R11: simultaneous pins 16 and 17
        wr_win(8'h30, 32'h0000_0070);
        @(negedge clk); irq_pin[16] = 1'b1; irq_pin[17] = 1'b1;
        cyc(5);
        check("R11 lowest first", {24'h0, msg_vector}, 32'h70);
        rd_win(8'h32, d); check("R10 pin17 waiting", {31'h0, d[12]}, 32'h1);
        accept_one();
        check("R11 second", {24'h0, msg_vector}, 32'h71);
        accept_one();
        check("R11 empty", {31'h0, msg_valid}, 32'h0);
        rd_win(8'h30, d); check("R10 pin16 clear", {31'h0, d[12]}, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule